// File: doc/BRIEF.md
# Rectangular Pixel Transfer Engine

This engine walks a rectangle of W pixels by H lines and moves 32-bit pixel words between memory areas through one memory port that it alone drives. It can paint the destination with one constant color, copy a source area, pass a source through an external conversion datapath, or read two sources for an external blending datapath and store its result. Each area (foreground source, background source, destination) has its own start address and its own line offset. That offset lets the rectangle sit inside a larger frame.

Software programs the engine through a write-only register port and starts a job with a start bit. A busy level and a one-cycle done pulse report progress. The conversion and blending arithmetic sit outside the block. The engine shows the latched source words on `px_fg` / `px_bg` and takes the finished pixel back on `px_result`. A programmable dead-cycle count, placed after each completed bus access, limits how much of the memory bandwidth the engine takes.

Top module: `xfer2d_engine`

## Requirements
- R1: Registers are written through `cfg_we`/`cfg_addr`/`cfg_wdata`. Index 0 is control: bit 0 starts a job and bits 2:1 pick the mode (0 fill, 1 copy, 2 convert, 3 blend). Index 1 holds width in bits 15:0 and height in bits 31:16. Indices 2/3 hold the foreground base and offset, 4/5 the background base and offset, and 6/7 the destination base and offset. Index 8 is the fill color and index 9 is the dead-cycle count.
- R2: In fill mode every destination pixel is written with the fill color and no read is issued.
- R3: In copy mode each pixel is one foreground read followed by a destination write of the word that was read.
- R4: In convert mode each pixel is one foreground read, with the read word shown on `px_fg`, followed by a destination write of `px_result`.
- R5: In blend mode each pixel is a foreground read, then a background read, then a destination write of `px_result`, always in that order.
- R6: Within a line, each area's address steps by 4 bytes per pixel. Line n of an area starts at base + n*(W + offset)*4, where the offset is counted in pixels.
- R7: A job touches exactly W*H destination pixels, line by line with the pixels of each line in increasing order.
- R8: With a dead-cycle count N, exactly N cycles with `mem_req` low separate each accepted access from the next request of the same job.
- R9: Once `mem_req` is raised it stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until a cycle in which `mem_ack` is high.
- R10: A start written while busy is ignored: the running job keeps its mode and its access sequence, and only one done pulse follows.
- R11: `done` is high for one cycle, in the cycle after the final write is accepted, and `busy` is low in that cycle.
- R12: A start with width or height zero makes no access and raises `done` in the next cycle. When not busy, `mem_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted this cycle (read data valid) |
| mem_rdata | input | 32 | Read data |
| px_fg | output | 32 | Latched foreground word for the external datapath |
| px_bg | output | 32 | Latched background word for the external datapath |
| px_result | input | 32 | Converted or blended pixel from the external datapath |

## Verification
All four modes run on small rectangles with nonzero line offsets. The full access list (kind, address, write data) is compared against a model, so a wrong offset term, a swapped fg/bg order or a wrong write-data source each show up as a separate mismatch. A 1x1 job and jobs with zero width or zero height separate the end-of-line and end-of-job conditions from the no-access path. Dead-cycle counts of 0 and above, together with a memory that acknowledges after random delays, distinguish gap counting from request holding. One run writes a second start mid-job to confirm that it is ignored.

// File: rtl/xfer2d_pkg.sv
package xfer2d_pkg;
  typedef enum logic [1:0] {MD_FILL = 2'd0, MD_COPY = 2'd1, MD_CONV = 2'd2, MD_BLEND = 2'd3} mode_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RDFG = 2'd1, ST_RDBG = 2'd2, ST_WR = 2'd3} state_e;

  localparam int NCH       = 3;   // 0 foreground, 1 background, 2 destination
  localparam int REG_CTRL  = 0;
  localparam int REG_SIZE  = 1;
  localparam int REG_BASE0 = 2;   // channel c base at REG_BASE0 + 2c, offset at +1
  localparam int REG_COLOR = 8;
  localparam int REG_GAP   = 9;
endpackage

// File: rtl/xfer2d_cfg.sv
module xfer2d_cfg
  import xfer2d_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DIM_W = 16,
  parameter int OFF_W = 16,
  parameter int GAP_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [3:0]                addr,
  input  logic [31:0]               wdata,
  output logic [DIM_W-1:0]          width,
  output logic [DIM_W-1:0]          height,
  output logic [NCH-1:0][AW-1:0]    base,
  output logic [NCH-1:0][OFF_W-1:0] off,
  output logic [31:0]               color,
  output logic [GAP_W-1:0]          gap,
  output logic                      start,
  output mode_e                     start_mode
);
  localparam int HI = 16;

  logic wr_size, wr_color, wr_gap;

  assign wr_size  = we && (addr == 4'(REG_SIZE));
  assign wr_color = we && (addr == 4'(REG_COLOR));
  assign wr_gap   = we && (addr == 4'(REG_GAP));

  assign start      = we && (addr == 4'(REG_CTRL)) && wdata[0];
  assign start_mode = mode_e'(wdata[2:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width  <= '0;
      height <= '0;
    end else if (wr_size) begin
      width  <= wdata[DIM_W-1:0];
      height <= wdata[HI+DIM_W-1:HI];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        color <= '0;
    else if (wr_color) color <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap <= '0;
    else if (wr_gap) gap <= wdata[GAP_W-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [AW-1:0]    base_q;
    logic [OFF_W-1:0] off_q;
    logic             wr_base, wr_off;

    assign wr_base = we && (addr == 4'(REG_BASE0 + 2 * c));
    assign wr_off  = we && (addr == 4'(REG_BASE0 + 2 * c + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       base_q <= '0;
      else if (wr_base) base_q <= wdata[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      off_q <= '0;
      else if (wr_off) off_q <= wdata[OFF_W-1:0];
    end

    assign base[c] = base_q;
    assign off[c]  = off_q;
  end
endmodule

// File: rtl/xfer2d_agen.sv
module xfer2d_agen #(
  parameter int AW    = 32,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    base,
  input  logic             step,
  input  logic             eol,
  input  logic [OFF_W-1:0] off,
  output logic [AW-1:0]    addr
);
  localparam logic [AW-1:0] PIX_BYTES = AW'(4);

  logic [AW-1:0] addr_d, skip;

  // after the last pixel of a line, also jump over the offset pixels
  assign skip = eol ? AW'({off, 2'b00}) : '0;

  always_comb begin
    addr_d = addr;
    if (load)      addr_d = base;
    else if (step) addr_d = addr + PIX_BYTES + skip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            addr <= '0;
    else if (load || step) addr <= addr_d;
  end
endmodule

// File: rtl/xfer2d_gap.sv
module xfer2d_gap #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             arm,
  input  logic [GAP_W-1:0] len,
  output logic             hold
);
  logic [GAP_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)               cnt_d = '0;
    else if (arm)          cnt_d = len;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hold = (cnt_q != '0);
endmodule

// File: rtl/xfer2d_engine.sv
module xfer2d_engine
  import xfer2d_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DIM_W = 16,
  parameter int OFF_W = 16,
  parameter int GAP_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   px_fg,
  output logic [31:0]   px_bg,
  input  logic [31:0]   px_result
);
  logic [DIM_W-1:0]          cfg_w, cfg_h;
  logic [NCH-1:0][AW-1:0]    cfg_base;
  logic [NCH-1:0][OFF_W-1:0] cfg_off;
  logic [31:0]               cfg_color;
  logic [GAP_W-1:0]          gap_len;
  logic                      start_req;
  mode_e                     start_mode;

  state_e           st_q, st_d;
  mode_e            mode_q;
  logic [DIM_W-1:0] w_q, h_q, x_q, x_d, y_q, y_d;
  logic [31:0]      fg_q, bg_q;
  logic             done_d;
  logic [NCH-1:0][AW-1:0] ch_addr;

  logic start_go, zero_dims, acc, eol, last, pix_done, gap_hold, gap_arm;

  xfer2d_cfg #(.AW(AW), .DIM_W(DIM_W), .OFF_W(OFF_W), .GAP_W(GAP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .width(cfg_w), .height(cfg_h), .base(cfg_base), .off(cfg_off),
    .color(cfg_color), .gap(gap_len), .start(start_req), .start_mode(start_mode)
  );

  assign start_go  = start_req && (st_q == ST_IDLE);
  assign zero_dims = (cfg_w == '0) || (cfg_h == '0);
  assign acc       = mem_req && mem_ack;
  assign eol       = (x_q == w_q - 1'b1);
  assign last      = eol && (y_q == h_q - 1'b1);
  assign pix_done  = (st_q == ST_WR) && acc;
  assign gap_arm   = acc && !(pix_done && last);
  assign done_d    = (start_go && zero_dims) || (pix_done && last);

  for (genvar c = 0; c < NCH; c++) begin : g_agen
    xfer2d_agen #(.AW(AW), .OFF_W(OFF_W)) u_agen (
      .clk(clk), .rst_n(rst_n), .load(start_go), .base(cfg_base[c]),
      .step(pix_done), .eol(eol), .off(cfg_off[c]), .addr(ch_addr[c])
    );
  end

  xfer2d_gap #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .arm(gap_arm), .len(gap_len), .hold(gap_hold)
  );

  // next-state: pixel sequence fg -> bg -> write depending on mode
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start_go && !zero_dims) st_d = (start_mode == MD_FILL) ? ST_WR : ST_RDFG;
      ST_RDFG: if (acc) st_d = (mode_q == MD_BLEND) ? ST_RDBG : ST_WR;
      ST_RDBG: if (acc) st_d = ST_WR;
      ST_WR:   if (acc) st_d = last ? ST_IDLE : ((mode_q == MD_FILL) ? ST_WR : ST_RDFG);
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (start_go) begin
      x_d = '0;
      y_d = '0;
    end else if (pix_done) begin
      x_d = eol ? '0 : x_q + 1'b1;
      y_d = eol ? y_q + 1'b1 : y_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      x_q    <= '0;
      y_q    <= '0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      x_q    <= x_d;
      y_q    <= y_d;
      done   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_FILL;
      w_q    <= '0;
      h_q    <= '0;
    end else if (start_go) begin
      mode_q <= start_mode;
      w_q    <= cfg_w;
      h_q    <= cfg_h;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        fg_q <= '0;
    else if ((st_q == ST_RDFG) && acc) fg_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        bg_q <= '0;
    else if ((st_q == ST_RDBG) && acc) bg_q <= mem_rdata;
  end

  always_comb begin
    case (st_q)
      ST_RDFG: mem_addr = ch_addr[0];
      ST_RDBG: mem_addr = ch_addr[1];
      default: mem_addr = ch_addr[2];
    endcase
    case (mode_q)
      MD_FILL: mem_wdata = cfg_color;
      MD_COPY: mem_wdata = fg_q;
      default: mem_wdata = px_result;
    endcase
  end

  assign busy    = (st_q != ST_IDLE);
  assign mem_req = busy && !gap_hold;
  assign mem_we  = (st_q == ST_WR);
  assign px_fg   = fg_q;
  assign px_bg   = bg_q;
endmodule

// File: rtl/xfer2d_chk.sv
module xfer2d_chk #(
  parameter int AW    = 32,
  parameter int GAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [AW-1:0]    mem_addr,
  input logic [31:0]      mem_wdata,
  input logic [1:0]       mode,
  input logic [GAP_W-1:0] gap_len,
  input logic             start_go,
  input logic             zero_dims
);
  AST_FILL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode == 2'd0) |-> !(mem_req && !mem_we)); // R2

  AST_DEAD_AFTER_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && gap_len != '0) |=> !mem_req); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

  AST_BUSY_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(mem_req && mem_ack && mem_we)) |=> (busy && $stable(mode))); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start_go && zero_dims)) |=> !done); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R12

  AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go && zero_dims) |=> (done && !busy)); // R12
endmodule

bind xfer2d_engine xfer2d_chk #(.AW(AW), .GAP_W(GAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mode(mode_q), .gap_len(gap_len), .start_go(start_go), .zero_dims(zero_dims)
);

// File: tb/sim_xfer2d_engine.sv
module sim_xfer2d_engine;
  logic        clk, rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        busy, done, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, px_fg, px_bg, px_result;

  int n_chk = 0;
  int n_bad = 0;

  // job description
  int          jm, jw, jh, gap_tb;
  logic [31:0] jb [3];
  int          jo [3];
  logic [31:0] jcol;

  // expected and recorded access lists
  logic        exp_we [256];
  logic [31:0] exp_ad [256];
  logic [31:0] exp_dt [256];
  int          exp_n;
  logic        rec_we [256];
  logic [31:0] rec_ad [256];
  logic [31:0] rec_dt [256];
  int          rec_n;

  int cyc = 0, last_ack = 0, start_cyc = 0, done_cyc = 0, done_cnt = 0;
  int gap_bad = 0, hold_bad = 0, done_busy_bad = 0;
  logic        in_req = 0, hold_we;
  logic [31:0] hold_ad, hold_dt;

  // external datapath model
  assign px_result = (jm == 3) ? (px_fg + px_bg) : ~px_fg;

  xfer2d_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .px_fg(px_fg), .px_bg(px_bg), .px_result(px_result)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [31:0] rd_of(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h00C0FFEE;
  endfunction

  function automatic logic [31:0] res_of(int m, logic [31:0] f, logic [31:0] b);
    return (m == 3) ? (f + b) : ~f;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // memory responder and monitor (negedge, away from the active edge)
  initial begin
    mem_ack = 0;
    mem_rdata = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        mem_ack = 0;
      end else begin
        if (cfg_we && cfg_addr == 4'd0 && cfg_wdata[0] && !busy) start_cyc = cyc;
        if (done) begin
          done_cnt++;
          done_cyc = cyc;
          if (busy) done_busy_bad++;
        end
        if (mem_req) begin
          if (!in_req) begin
            in_req = 1;
            hold_ad = mem_addr; hold_we = mem_we; hold_dt = mem_wdata;
            if (rec_n > 0 && (cyc - last_ack - 1) != gap_tb) gap_bad++;
          end else if (mem_addr != hold_ad || mem_we != hold_we || mem_wdata != hold_dt) begin
            hold_bad++;
          end
          if ($urandom % 3 != 0) begin
            mem_ack = 1;
            mem_rdata = rd_of(mem_addr);
            if (rec_n < 256) begin
              rec_we[rec_n] = mem_we; rec_ad[rec_n] = mem_addr; rec_dt[rec_n] = mem_wdata;
            end
            rec_n++;
            in_req = 0;
            last_ack = cyc;
          end else begin
            mem_ack = 0;
          end
        end else begin
          mem_ack = 0;
        end
      end
    end
  end

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(posedge clk); #2;
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 0;
  endtask

  task automatic build_exp();
    logic [31:0] fa, ba, da, fv, bv;
    exp_n = 0;
    for (int y = 0; y < jh; y++) begin
      for (int x = 0; x < jw; x++) begin
        fa = jb[0] + 32'((y * (jw + jo[0]) + x) * 4);
        ba = jb[1] + 32'((y * (jw + jo[1]) + x) * 4);
        da = jb[2] + 32'((y * (jw + jo[2]) + x) * 4);
        fv = rd_of(fa);
        bv = rd_of(ba);
        if (jm != 0) begin
          exp_we[exp_n] = 0; exp_ad[exp_n] = fa; exp_dt[exp_n] = 0; exp_n++;
        end
        if (jm == 3) begin
          exp_we[exp_n] = 0; exp_ad[exp_n] = ba; exp_dt[exp_n] = 0; exp_n++;
        end
        exp_we[exp_n] = 1; exp_ad[exp_n] = da;
        exp_dt[exp_n] = (jm == 0) ? jcol : (jm == 1) ? fv : res_of(jm, fv, bv);
        exp_n++;
      end
    end
  endtask

  task automatic run_job(input bit restart_mid);
    string mtag;
    int t, bad_kind, bad_ad, bad_dt, first;
    mtag = (jm == 0) ? "R2" : (jm == 1) ? "R3" : (jm == 2) ? "R4" : "R5";
    build_exp();
    @(posedge clk); #2;
    rec_n = 0; done_cnt = 0; gap_bad = 0; hold_bad = 0; done_busy_bad = 0;
    wr_reg(1, {16'(jh), 16'(jw)});
    for (int c = 0; c < 3; c++) begin
      wr_reg(2 + 2 * c, jb[c]);
      wr_reg(3 + 2 * c, 32'(jo[c]));
    end
    wr_reg(8, jcol);
    wr_reg(9, 32'(gap_tb));
    wr_reg(0, {29'd0, 2'(jm), 1'b1});
    if (restart_mid) begin
      t = 0;
      while (rec_n < 1 && t < 2000) begin @(posedge clk); t++; end
      wr_reg(0, {29'd0, 2'(jm ^ 3), 1'b1}); // R10: start while busy
    end
    t = 0;
    while (done_cnt == 0 && t < 5000) begin @(posedge clk); t++; end
    repeat (12) @(posedge clk);
    #2;
    bad_kind = 0; bad_ad = 0; bad_dt = 0; first = -1;
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      if (rec_we[i] != exp_we[i]) begin bad_kind++; if (first < 0) first = i; end
      else if (rec_ad[i] != exp_ad[i]) begin bad_ad++; if (first < 0) first = i; end
      else if (exp_we[i] && rec_dt[i] != exp_dt[i]) begin bad_dt++; if (first < 0) first = i; end
    end
    if (exp_n == 0) begin
      chk(rec_n == 0, "R12", "no access on zero size", 32'(rec_n), 0);
      chk(done_cnt == 1 && done_cyc == start_cyc + 1, "R12", "done cycle after zero start",
          32'(done_cyc - start_cyc), 1);
    end else begin
      chk(rec_n == exp_n, "R7", "access count", 32'(rec_n), 32'(exp_n));
      chk(bad_kind == 0, {mtag, " R1"}, "access order/kind", 32'(first), 32'(-1));
      chk(bad_ad == 0, "R6", "address sequence", 32'(first), 32'(-1));
      chk(bad_dt == 0, mtag, "write data", 32'(first), 32'(-1));
      chk(gap_bad == 0, "R8", "dead cycles between accesses", 32'(gap_bad), 0);
      chk(hold_bad == 0, "R9", "request held stable", 32'(hold_bad), 0);
      chk(done_cnt == 1 && done_cyc == last_ack + 1 && done_busy_bad == 0, "R11",
          "done pulse timing", 32'(done_cyc - last_ack), 1);
      if (restart_mid)
        chk(rec_n == exp_n && done_cnt == 1, "R10", "restart ignored", 32'(done_cnt), 1);
    end
  endtask

  task automatic set_job(int m, int w, int h, int g, logic [31:0] b0, logic [31:0] b1, logic [31:0] b2,
                         int o0, int o1, int o2);
    jm = m; jw = w; jh = h; gap_tb = g;
    jb[0] = b0; jb[1] = b1; jb[2] = b2;
    jo[0] = o0; jo[1] = o1; jo[2] = o2;
    jcol = 32'hC0DE_0000 + 32'(m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    jm = 0; jw = 0; jh = 0; gap_tb = 0; jcol = 0; exp_n = 0; rec_n = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R12", "reset state idle and quiet",
        {29'd0, busy, done, mem_req}, 0);

    set_job(0, 3, 2, 0, 32'h0, 32'h0, 32'h0000_1000, 0, 0, 5);      run_job(0);
    set_job(1, 4, 3, 0, 32'h0000_2000, 32'h0, 32'h0000_3000, 2, 0, 1); run_job(0);
    set_job(2, 2, 3, 2, 32'h0000_4000, 32'h0, 32'h0000_5000, 6, 0, 0); run_job(0);
    set_job(3, 3, 2, 1, 32'h0000_6000, 32'h0000_7000, 32'h0000_8000, 1, 3, 2); run_job(0);
    set_job(3, 1, 1, 0, 32'hFFFF_FFF8, 32'h0000_0010, 32'h0000_0020, 0, 0, 0); run_job(0);
    set_job(1, 0, 4, 0, 32'h100, 32'h200, 32'h300, 0, 0, 0);        run_job(0);
    set_job(0, 4, 0, 0, 32'h100, 32'h200, 32'h300, 0, 0, 0);        run_job(0);
    set_job(3, 3, 3, 3, 32'h0000_9000, 32'h0000_A000, 32'h0000_B000, 2, 2, 2); run_job(1);

    for (int k = 0; k < 8; k++) begin
      set_job(int'($urandom % 4), 1 + int'($urandom % 4), 1 + int'($urandom % 3), int'($urandom % 3),
              $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC,
              int'($urandom % 6), int'($urandom % 6), int'($urandom % 6));
      run_job(0);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule